// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block sits on a small processor bus and provides three 8-bit general-purpose ports, named A, B and C, along with one control register. A 2-bit address picks the target of each access, and an active-low chip select qualifies every transfer. Active-low read and write strobes mark each access. Each port pin has three separate vectors: an input, an output value and an output enable. These connect to pad cells or to other on-chip logic.

Software sets the port directions with a mode word. Ports A and B are each all-input or all-output. The two 4-bit halves of port C take their directions independently of each other. The control register has two meanings, chosen by the top bit of the written byte. When that bit is set, the byte is a mode word: it sets the directions and clears every output latch. When that bit is clear, the byte is a single-bit command that sets or clears one port C line. Only basic input/output operation is implemented. The mode-select fields of the word are stored and read back, but they do not change behaviour.

The design is fully synchronous with an active-high synchronous reset. The bus decodes the strobes as levels on each rising clock edge. Read data and its output enable are registered.

Top module: `ppi_ctrl`

## Requirements
- R1: On an edge where `cs_n` is low, address 0 accesses port A, 1 accesses port B, 2 accesses port C and 3 accesses the control register. While `cs_n` is high, no strobe changes any latch, direction or bus output.
- R2: After reset, all output latches are 0 and all output enables are 0 (every line is an input). `dout_oe` is 0, and the control register reads back 0x9B.
- R3: In a mode word, bit 4 makes port A an input, bit 1 makes port B an input, bit 3 makes port C bits 7:4 an input and bit 0 makes port C bits 3:0 an input (1 = input, 0 = output). Each output enable bit is 1 exactly on lines configured as outputs.
- R4: Mode word 0x80 makes every line an output, 0x9B makes every line an input, and 0x99 makes only port B an output.
- R5: Writing any mode word clears all port A, B and C output latches to 0.
- R6: A control write with bit 7 = 0 loads bit 0 into port C line `din[3:1]`, but only if that line's half is an output. Such a write leaves the stored mode word unchanged.
- R7: A control register read returns the last mode word with bit 7 always 1.
- R8: A port read returns the pin input sampled at the read edge for lines configured as inputs, and the output latch for lines configured as outputs.
- R9: A port C write updates only the latch bits of the halves configured as outputs. A port A or B write loads the whole latch when that port is an output.
- R10: `dout_oe` is 1 in the cycle after an edge with `cs_n` and `rd_n` both low, and 0 after any other edge. `dout` carries the read value in that cycle.
- R11: A write to a port takes effect on `port_*_out` in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from bus |
| dout | output | 8 | Registered read data |
| dout_oe | output | 1 | Read data valid / bus drive enable |
| port_a_in | input | 8 | Port A pin inputs |
| port_a_out | output | 8 | Port A output latch |
| port_a_oe | output | 8 | Port A output enables |
| port_b_in | input | 8 | Port B pin inputs |
| port_b_out | output | 8 | Port B output latch |
| port_b_oe | output | 8 | Port B output enables |
| port_c_in | input | 8 | Port C pin inputs |
| port_c_out | output | 8 | Port C output latch |
| port_c_oe | output | 8 | Port C output enables |

## Verification
The bench targets the split directions of port C. If a design applied a whole-port write or a single-bit command to an input half, bits would appear on `port_c_out` for that half. If it read a latch where a pin input belongs, the read value would be wrong. The bench also checks that a single-bit command leaves the read-back mode word alone; a design that stored the command as a mode word would change the directions and clear the latches. Other targets are the reset read-back value, the forced top bit on read-back, and strobes with chip select high. Random streams of mode words, commands, writes and reads with changing pin inputs are compared against a bench model.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // direction bit positions inside a mode word (1 = input)
  localparam int MW_CL_IN = 0;
  localparam int MW_B_IN  = 1;
  localparam int MW_CU_IN = 3;
  localparam int MW_A_IN  = 4;
  localparam int MW_FLAG  = 7;

  localparam logic [7:0] MW_RESET = 8'h9B;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;

  function automatic dir_t mw_dirs(input logic [7:0] w);
    dir_t d;
    d.a_in  = w[MW_A_IN];
    d.b_in  = w[MW_B_IN];
    d.cu_in = w[MW_CU_IN];
    d.cl_in = w[MW_CL_IN];
    return d;
  endfunction

endpackage

// File: rtl/ppi_bus_dec.sv
module ppi_bus_dec
  import ppi_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [2:0] wr_port,
  output logic       wr_mode,
  output logic       wr_bitop,
  output logic       rd_req
);

  logic wr_act;
  sel_e sel;

  assign sel    = sel_e'(addr);
  assign wr_act = !cs_n && !wr_n;
  assign rd_req = !cs_n && !rd_n;

  always_comb begin
    wr_port  = '0;
    wr_mode  = 1'b0;
    wr_bitop = 1'b0;
    if (wr_act) begin
      case (sel)
        SEL_A:    wr_port[0] = 1'b1;
        SEL_B:    wr_port[1] = 1'b1;
        SEL_C:    wr_port[2] = 1'b1;
        default: begin
          wr_mode  = din[MW_FLAG];
          wr_bitop = !din[MW_FLAG];
        end
      endcase
    end
  end

endmodule

// File: rtl/ppi_mode_reg.sv
module ppi_mode_reg
  import ppi_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] mode_word,
  output dir_t         dirs
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_word <= W'(MW_RESET);
    end else if (wr_mode) begin
      mode_word <= din;
    end
  end

  assign dirs = mw_dirs(8'(mode_word));

endmodule

// File: rtl/ppi_lane.sv
module ppi_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         is_input,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lat,
  output logic [W-1:0] oe,
  output logic [W-1:0] rd_val
);

  logic [W-1:0] eff_mask;

  assign eff_mask = wr_mask & {W{!is_input}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lat <= '0;
    end else begin
      lat <= (lat & ~eff_mask) | (wr_data & eff_mask);
    end
  end

  assign oe     = {W{!is_input}};
  assign rd_val = is_input ? pin_in : lat;

endmodule

// File: rtl/ppi_rd_path.sv
module ppi_rd_path
  import ppi_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_req,
  input  logic [1:0]   addr,
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] b_val,
  input  logic [W-1:0] c_val,
  input  logic [W-1:0] mode_word,
  output logic [W-1:0] dout,
  output logic         dout_oe
);

  logic [W-1:0] rd_mux;

  always_comb begin
    case (sel_e'(addr))
      SEL_A:   rd_mux = a_val;
      SEL_B:   rd_mux = b_val;
      SEL_C:   rd_mux = c_val;
      default: begin
        rd_mux          = mode_word;
        rd_mux[MW_FLAG] = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_req;
      if (rd_req) begin
        dout <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout,
  output logic              dout_oe,
  input  logic [PORT_W-1:0] port_a_in,
  output logic [PORT_W-1:0] port_a_out,
  output logic [PORT_W-1:0] port_a_oe,
  input  logic [PORT_W-1:0] port_b_in,
  output logic [PORT_W-1:0] port_b_out,
  output logic [PORT_W-1:0] port_b_oe,
  input  logic [PORT_W-1:0] port_c_in,
  output logic [PORT_W-1:0] port_c_out,
  output logic [PORT_W-1:0] port_c_oe
);

  localparam int HALF  = PORT_W / 2;
  localparam int IDX_W = $clog2(PORT_W);

  logic [2:0]        wr_port;
  logic              wr_mode;
  logic              wr_bitop;
  logic              rd_req;
  logic [PORT_W-1:0] mode_word;
  dir_t              dirs;
  logic [PORT_W-1:0] a_rd;
  logic [PORT_W-1:0] b_rd;
  logic [PORT_W-1:0] c_rd;
  logic [PORT_W-1:0] c_mask;
  logic [PORT_W-1:0] c_data;
  logic [PORT_W-1:0] bit_sel;
  logic [1:0]        c_half_in;

  ppi_bus_dec u_dec (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .din      (8'(din)),
    .wr_port  (wr_port),
    .wr_mode  (wr_mode),
    .wr_bitop (wr_bitop),
    .rd_req   (rd_req)
  );

  ppi_mode_reg #(.W(PORT_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .wr_mode   (wr_mode),
    .din       (din),
    .mode_word (mode_word),
    .dirs      (dirs)
  );

  ppi_lane #(.W(PORT_W)) u_lane_a (
    .clk      (clk),
    .rst      (rst),
    .clr      (wr_mode),
    .is_input (dirs.a_in),
    .wr_mask  ({PORT_W{wr_port[0]}}),
    .wr_data  (din),
    .pin_in   (port_a_in),
    .lat      (port_a_out),
    .oe       (port_a_oe),
    .rd_val   (a_rd)
  );

  ppi_lane #(.W(PORT_W)) u_lane_b (
    .clk      (clk),
    .rst      (rst),
    .clr      (wr_mode),
    .is_input (dirs.b_in),
    .wr_mask  ({PORT_W{wr_port[1]}}),
    .wr_data  (din),
    .pin_in   (port_b_in),
    .lat      (port_b_out),
    .oe       (port_b_oe),
    .rd_val   (b_rd)
  );

  // single-bit command: one-hot select from the index field
  always_comb begin
    bit_sel = '0;
    bit_sel[din[IDX_W:1]] = 1'b1;
  end

  assign c_mask    = wr_port[2] ? '1  : (wr_bitop ? bit_sel : '0);
  assign c_data    = wr_port[2] ? din : {PORT_W{din[0]}};
  assign c_half_in = {dirs.cu_in, dirs.cl_in};

  for (genvar g = 0; g < 2; g++) begin : g_c_half
    ppi_lane #(.W(HALF)) u_lane_c (
      .clk      (clk),
      .rst      (rst),
      .clr      (wr_mode),
      .is_input (c_half_in[g]),
      .wr_mask  (c_mask[g*HALF +: HALF]),
      .wr_data  (c_data[g*HALF +: HALF]),
      .pin_in   (port_c_in[g*HALF +: HALF]),
      .lat      (port_c_out[g*HALF +: HALF]),
      .oe       (port_c_oe[g*HALF +: HALF]),
      .rd_val   (c_rd[g*HALF +: HALF])
    );
  end

  ppi_rd_path #(.W(PORT_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .addr      (addr),
    .a_val     (a_rd),
    .b_val     (b_rd),
    .c_val     (c_rd),
    .mode_word (mode_word),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

endmodule

// File: rtl/ppi_ctrl_chk.sv
module ppi_ctrl_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [1:0]        addr,
  input logic [PORT_W-1:0] din,
  input logic [PORT_W-1:0] dout,
  input logic              dout_oe,
  input logic [PORT_W-1:0] port_a_out,
  input logic [PORT_W-1:0] port_a_oe,
  input logic [PORT_W-1:0] port_b_out,
  input logic [PORT_W-1:0] port_b_oe,
  input logic [PORT_W-1:0] port_c_out,
  input logic [PORT_W-1:0] port_c_oe
);

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> ($past(!cs_n) && $past(!rd_n))); // R10

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n) |=> dout_oe); // R10

  AST_NO_CS_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(port_a_out) && $stable(port_b_out) && $stable(port_c_out)
              && $stable(port_a_oe) && $stable(port_c_oe))); // R1

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && addr == 2'd3 && din[7])
      |=> (port_a_out == '0 && port_b_out == '0 && port_c_out == '0)); // R5

  AST_CTRL_FLAG_READS_ONE: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(addr) == 2'd3) |-> dout[7]); // R7

  AST_WHOLE_PORT_DIR: assert property (@(posedge clk) disable iff (rst)
    ((port_a_oe == '0 || port_a_oe == '1) && (port_b_oe == '0 || port_b_oe == '1))); // R3

  AST_BITOP_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && addr == 2'd3 && !din[7])
      |=> ($countones(port_c_out ^ $past(port_c_out)) <= 1
           && $stable(port_c_oe))); // R6

endmodule

bind ppi_ctrl ppi_ctrl_chk #(.PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .addr       (addr),
  .din        (din),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .port_a_out (port_a_out),
  .port_a_oe  (port_a_oe),
  .port_b_out (port_b_out),
  .port_b_oe  (port_b_oe),
  .port_c_out (port_c_out),
  .port_c_oe  (port_c_oe)
);

// File: tb/ppi_ctrl_tb_top.sv
module ppi_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic       dout_oe;
  logic [7:0] pa_in, pa_out, pa_oe;
  logic [7:0] pb_in, pb_out, pb_oe;
  logic [7:0] pc_in, pc_out, pc_oe;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model
  logic [7:0] m_mode;
  logic [7:0] m_a, m_b, m_c;

  always #5 clk = ~clk;

  ppi_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .port_a_in(pa_in), .port_a_out(pa_out), .port_a_oe(pa_oe),
    .port_b_in(pb_in), .port_b_out(pb_out), .port_b_oe(pb_oe),
    .port_c_in(pc_in), .port_c_out(pc_out), .port_c_oe(pc_oe)
  );

  function automatic logic [7:0] oe_a(input logic [7:0] w);
    return w[4] ? 8'h00 : 8'hFF;
  endfunction
  function automatic logic [7:0] oe_b(input logic [7:0] w);
    return w[1] ? 8'h00 : 8'hFF;
  endfunction
  function automatic logic [7:0] oe_c(input logic [7:0] w);
    return {w[3] ? 4'h0 : 4'hF, w[0] ? 4'h0 : 4'hF};
  endfunction
  function automatic logic [7:0] rd_exp(input logic [1:0] ad);
    case (ad)
      2'd0:    return (pa_in & ~oe_a(m_mode)) | (m_a & oe_a(m_mode));
      2'd1:    return (pb_in & ~oe_b(m_mode)) | (m_b & oe_b(m_mode));
      2'd2:    return (pc_in & ~oe_c(m_mode)) | (m_c & oe_c(m_mode));
      default: return m_mode | 8'h80;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_ports(input string tag);
    chk({tag, " a_out"}, pa_out, m_a);
    chk({tag, " b_out"}, pb_out, m_b);
    chk({tag, " c_out"}, pc_out, m_c);
    chk({tag, " a_oe"},  pa_oe,  oe_a(m_mode));
    chk({tag, " b_oe"},  pb_oe,  oe_b(m_mode));
    chk({tag, " c_oe"},  pc_oe,  oe_c(m_mode));
  endtask

  task automatic model_wr(input logic [1:0] ad, input logic [7:0] d);
    case (ad)
      2'd0: m_a = oe_a(m_mode) != 0 ? d : m_a;
      2'd1: m_b = oe_b(m_mode) != 0 ? d : m_b;
      2'd2: m_c = (m_c & ~oe_c(m_mode)) | (d & oe_c(m_mode));
      default:
        if (d[7]) begin
          m_mode = d; m_a = 0; m_b = 0; m_c = 0;
        end else if (oe_c(m_mode)[d[3:1]]) begin
          m_c[d[3:1]] = d[0];
        end
    endcase
  endtask

  // writes land one cycle after the strobe edge (R11)
  task automatic bus_wr(input logic [1:0] ad, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = ad; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    model_wr(ad, d);
  endtask

  // read data is registered at the strobe edge (R10, R8)
  task automatic bus_rd(input string tag, input logic [1:0] ad);
    logic [7:0] e;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = ad;
    e = rd_exp(ad);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    chk({tag, " R10 oe"}, {7'd0, dout_oe}, 8'd1);
    chk({tag, " data"}, dout, e);
    @(negedge clk);
    chk({tag, " R10 oe drop"}, {7'd0, dout_oe}, 8'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; din = 0;
    pa_in = 8'h3C; pb_in = 8'hA5; pc_in = 8'h69;
    rst = 1;
    m_mode = 8'h9B; m_a = 0; m_b = 0; m_c = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset state
    chk_ports("R2 reset");
    chk("R2 dout_oe", {7'd0, dout_oe}, 8'd0);
    bus_rd("R2 ctrl readback", 2'd3);
    bus_rd("R8 input A", 2'd0);

    // R4 all outputs
    bus_wr(2'd3, 8'h80);
    chk_ports("R4 0x80");
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'hF0);
    chk_ports("R11 R1 writes");
    bus_rd("R8 A latch", 2'd0);
    bus_rd("R1 B latch", 2'd1);
    bus_rd("R1 C latch", 2'd2);

    // R1 chip select high blocks writes
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hFF;
    @(negedge clk);
    wr_n = 1'b1; addr = 2'd3; din = 8'h9B; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    chk_ports("R1 cs high");
    chk("R1 cs high no read", {7'd0, dout_oe}, 8'd0);

    // R5 mode write clears latches
    bus_wr(2'd3, 8'h80);
    chk_ports("R5 clear");
    chk("R5 a zero", pa_out, 8'h00);

    // R6 bit set on output half, mode unchanged
    bus_wr(2'd3, 8'h0B);   // set bit 5
    bus_wr(2'd3, 8'h02);   // clear bit 1 (already 0)
    bus_wr(2'd3, 8'h03);   // set bit 1
    chk("R6 c bits", pc_out, 8'h22);
    bus_rd("R6 R7 mode kept", 2'd3);

    // R4 0x99: A, C inputs, B output; R6 on input half ignored
    bus_wr(2'd3, 8'h99);
    chk_ports("R4 0x99");
    bus_wr(2'd3, 8'h0F);   // set bit 7, C upper is input
    chk("R6 ignored input half", pc_out, 8'h00);
    bus_rd("R8 C inputs", 2'd2);

    // R9 split port C: lower out, upper in (0x88)
    bus_wr(2'd3, 8'h88);
    bus_wr(2'd2, 8'hFF);
    chk("R9 lower only", pc_out, 8'h0F);
    chk("R3 c_oe split", pc_oe, 8'h0F);
    bus_rd("R9 R8 C mixed", 2'd2);
    bus_wr(2'd3, 8'h81);   // upper out, lower in
    bus_wr(2'd2, 8'hA7);
    chk("R9 upper only", pc_out, 8'hA0);

    // R4 0x9B all inputs
    bus_wr(2'd3, 8'h9B);
    chk_ports("R4 0x9B");

    // random mix against model (R1 R3 R5 R6 R7 R8 R9)
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      if (op == 0)      bus_wr(2'd3, {1'b1, 7'($urandom)});
      else if (op < 3)  bus_wr(2'd3, {4'd0, 4'($urandom)});
      else if (op < 6)  bus_wr(2'($urandom_range(0, 2)), 8'($urandom));
      else              bus_rd("R8 random read", 2'($urandom));
      chk_ports("R3 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule